// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block turns an active-low external interrupt pin into a maskable interrupt request for a CPU. The pin goes through a synchronizer, and then a falling-edge detector. A pending latch holds each request until software acknowledges it through the control register, or until the CPU strobes a vector fetch. A mode bit selects how the pin is sensed. In edge mode only falling edges set the latch. In level mode a pin held low also keeps setting it.

Software uses one 8-bit status and control register. Reading it returns the pending flag, the mask bit and the mode bit. Writing it updates the mask and the mode, and can acknowledge the pending request. While a debug break is in progress, a clear-enable input decides whether acknowledges and vector fetches can clear the latch. When that input is 0, the latch is protected. A clear made during the break stays in effect after the break ends.

Top module: `extint_top`

## Requirements
- R1: After reset the register reads 0x00 and `irqReq` is 0.
- R2: The register reads as {4'b0, pending, 1'b0, mask, mode}, with pending at bit 3, mask at bit 1 and mode at bit 0. Bits 7:4 read 0 and bit 2 (acknowledge) reads 0. A write takes the mask from bit 1 and the mode from bit 0, and ignores bits 7:3.
- R3: A 1-to-0 transition of `pinN` sets the pending flag at the third rising clock edge after the change, because of the two-stage synchronizer.
- R4: With mode 0, a pin that stays low after its falling edge does not set the latch again once it has been cleared.
- R5: With mode 1, a pin that stays low sets the latch again one cycle after a clear, and keeps doing so until the pin returns high.
- R6: A register write with bit 2 = 1 clears the pending latch at that clock edge, provided no new falling edge is detected in the same cycle.
- R7: A `vecFetch` pulse clears the pending latch under the same rules as an acknowledge.
- R8: With mask = 1, `irqReq` stays 0, yet the latch still captures requests and the pending flag shows them. Clearing the mask raises `irqReq` if a request is pending.
- R9: While `brkActive` = 1 and `brkClrEn` = 0, acknowledges and vector fetches leave the latch unchanged. Mask and mode writes still take effect.
- R10: While `brkActive` = 1 and `brkClrEn` = 1, an acknowledge clears the latch, and the latch stays clear after `brkActive` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinN | input | 1 | External active-low interrupt pin, asynchronous |
| regWr | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational |
| vecFetch | input | 1 | Interrupt vector fetch strobe from the CPU |
| brkActive | input | 1 | Debug break state is active |
| brkClrEn | input | 1 | Allows clears while in break |
| irqReq | output | 1 | Interrupt request to the CPU |

## Verification
A latch that is stuck set or stuck clear shows up at the ports within three cycles of a pin edge, as bit 3 of the read data and as `irqReq`. A lost or spurious clear shows up on the cycle after the acknowledge or vector-fetch strobe. A mode register that does not track writes shows up as a missing re-assertion one cycle after a clear while the pin is held low. A broken break gate shows up as a pending flag that drops while the break is active with clear-enable low.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int REG_W    = 8;
  localparam int PEND_BIT = 3;
  localparam int ACK_BIT  = 2;
  localparam int MASK_BIT = 1;
  localparam int MODE_BIT = 0;

  typedef struct packed {
    logic clrGo;    // qualified clear of the pending latch
    logic lvlMode;  // 1: low level also requests
    logic maskOn;   // 1: request output blocked
  } dpCtl_t;
endpackage

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [REG_W-1:0] regWrData,
  input  logic             vecFetch,
  input  logic             brkActive,
  input  logic             brkClrEn,
  input  logic             pending,
  output dpCtl_t           ctl,
  output logic [REG_W-1:0] regRdData
);
  logic maskQ;
  logic modeQ;
  logic ackReq;
  logic clrReq;
  logic clrAllowed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= 1'b0;
      modeQ <= 1'b0;
    end else if (regWr) begin
      maskQ <= regWrData[MASK_BIT];
      modeQ <= regWrData[MODE_BIT];
    end
  end

  always_comb begin
    ackReq     = regWr & regWrData[ACK_BIT];
    clrReq     = ackReq | vecFetch;
    clrAllowed = ~brkActive | brkClrEn;
    ctl.clrGo   = clrReq & clrAllowed;
    ctl.lvlMode = modeQ;
    ctl.maskOn  = maskQ;
  end

  always_comb begin
    regRdData           = '0;
    regRdData[PEND_BIT] = pending;
    regRdData[MASK_BIT] = maskQ;
    regRdData[MODE_BIT] = modeQ;
  end

  // R2: unimplemented and write-only bits always read zero
  assert_rdzero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[REG_W-1:PEND_BIT+1] == '0) && !regRdData[ACK_BIT]);

  // R9: a protected break never lets a pending request drop
  assert_break_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (brkActive && !brkClrEn && pending) |=> pending);
endmodule

// File: rtl/extint_datapath.sv
module extint_datapath
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   pinN,
  input  dpCtl_t ctl,
  output logic   pending,
  output logic   irqReq
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic pinSync;
  logic prevQ;
  logic pendQ;
  logic fallNow;
  logic lvlNow;
  logic pendNext;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : gSync
      if (gi == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[gi] <= 1'b1;
          else       syncQ[gi] <= pinN;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[gi] <= 1'b1;
          else       syncQ[gi] <= syncQ[gi-1];
        end
      end
    end
  endgenerate

  assign pinSync = syncQ[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b1;
    else       prevQ <= pinSync;
  end

  always_comb begin
    fallNow  = prevQ & ~pinSync;
    lvlNow   = ctl.lvlMode & ~pinSync;
    // an edge wins over a same-cycle clear; a level waits one cycle
    pendNext = fallNow | ((pendQ | lvlNow) & ~ctl.clrGo);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= 1'b0;
    else       pendQ <= pendNext;
  end

  assign pending = pendQ;
  assign irqReq  = pendQ & ~ctl.maskOn;

  // R3: a detected falling edge always lands in the latch
  assert_edge_sets_R3: assert property (@(posedge clk) disable iff (!rstN)
    fallNow |=> pendQ);

  // R6: a qualified clear without a new edge empties the latch
  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clrGo && !fallNow) |=> !pendQ);

  // R4: in edge mode an empty latch only fills on an edge
  assert_edge_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.lvlMode && !fallNow && !pendQ) |=> !pendQ);
endmodule

// File: rtl/extint_top.sv
module extint_top
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinN,
  input  logic             regWr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             vecFetch,
  input  logic             brkActive,
  input  logic             brkClrEn,
  output logic             irqReq
);
  dpCtl_t ctl;
  logic   pending;

  extint_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regWrData (regWrData),
    .vecFetch  (vecFetch),
    .brkActive (brkActive),
    .brkClrEn  (brkClrEn),
    .pending   (pending),
    .ctl       (ctl),
    .regRdData (regRdData)
  );

  extint_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pinN    (pinN),
    .ctl     (ctl),
    .pending (pending),
    .irqReq  (irqReq)
  );

  // R8: the mask held by control always silences the datapath output
  assert_mask_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[MASK_BIT] |-> !irqReq);
endmodule

// File: tb/sim_extint_top.sv
module sim_extint_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 21;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pinN = 1'b1;
  logic       regWr = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       vecFetch = 1'b0;
  logic       brkActive = 1'b0;
  logic       brkClrEn = 1'b0;
  logic       irqReq;

  int nChecks = 0;
  int nFails  = 0;

  typedef struct packed {
    logic       pin;
    logic       wr;
    logic [7:0] data;
    logic       vec;
    logic       brk;
    logic       bce;
    logic [3:0] w;
    logic [7:0] expRd;
    logic       expIrq;
  } vec_t;

  // pin, wr, data, vec, brk, bce, cycles, expected read, expected irq
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd3, 8'h00, 1'b0}, // 0 R1 idle
    '{1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd3, 8'h08, 1'b1}, // 1 R3 falling edge
    '{1'b0, 1'b1, 8'h04, 1'b0, 1'b0, 1'b0, 4'd3, 8'h00, 1'b0}, // 2 R4 ack, held low
    '{1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd3, 8'h00, 1'b0}, // 3 R4 release
    '{1'b1, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 4'd3, 8'h01, 1'b0}, // 4 R2 level mode
    '{1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd3, 8'h09, 1'b1}, // 5 R3 edge in level
    '{1'b0, 1'b1, 8'h05, 1'b0, 1'b0, 1'b0, 4'd1, 8'h01, 1'b0}, // 6 R6 ack clears
    '{1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd1, 8'h09, 1'b1}, // 7 R5 re-assert
    '{1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd3, 8'h09, 1'b1}, // 8 R5 stays pending
    '{1'b1, 1'b1, 8'h07, 1'b0, 1'b0, 1'b0, 4'd2, 8'h03, 1'b0}, // 9 R6 ack + mask
    '{1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd3, 8'h0B, 1'b0}, // 10 R8 masked capture
    '{1'b0, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 4'd1, 8'h09, 1'b1}, // 11 R8 unmask
    '{1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 4'd1, 8'h08, 1'b1}, // 12 R2 edge mode back
    '{1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd3, 8'h08, 1'b1}, // 13 R3 held
    '{1'b1, 1'b1, 8'h04, 1'b0, 1'b1, 1'b0, 4'd2, 8'h08, 1'b1}, // 14 R9 ack blocked
    '{1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 4'd2, 8'h08, 1'b1}, // 15 R9 fetch blocked
    '{1'b1, 1'b1, 8'h04, 1'b0, 1'b1, 1'b1, 4'd2, 8'h00, 1'b0}, // 16 R10 ack in break
    '{1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd3, 8'h00, 1'b0}, // 17 R10 stays clear
    '{1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd3, 8'h08, 1'b1}, // 18 R3 new edge
    '{1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd2, 8'h00, 1'b0}, // 19 R7 fetch clears
    '{1'b1, 1'b1, 8'hF0, 1'b0, 1'b0, 1'b0, 4'd3, 8'h00, 1'b0}  // 20 R2 upper ignored
  };

  localparam string REQS [NVEC] = '{
    "R1", "R3", "R4", "R4", "R2", "R3", "R6", "R5", "R5", "R6", "R8",
    "R8", "R2", "R3", "R9", "R9", "R10", "R10", "R3", "R7", "R2"
  };

  extint_top u0 (
    .clk       (clk),
    .rstN      (rstN),
    .pinN      (pinN),
    .regWr     (regWr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .vecFetch  (vecFetch),
    .brkActive (brkActive),
    .brkClrEn  (brkClrEn),
    .irqReq    (irqReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] expRd, input logic expIrq);
    nChecks++;
    if (regRdData !== expRd || irqReq !== expIrq) begin
      nFails++;
      $display("FAIL %s: read %02h irq %b, expected read %02h irq %b",
               req, regRdData, irqReq, expRd, expIrq);
    end
  endtask

  task automatic runVec(input vec_t v, input string req);
    pinN      = v.pin;
    regWr     = v.wr;
    regWrData = v.data;
    vecFetch  = v.vec;
    brkActive = v.brk;
    brkClrEn  = v.bce;
    for (int k = 0; k < int'(v.w); k++) begin
      @(negedge clk);
      regWr    = 1'b0;
      vecFetch = 1'b0;
    end
    check(req, v.expRd, v.expIrq);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 8'h00, 1'b0);  // R1 state under reset
    rstN = 1'b1;
    @(negedge clk);
    check("R1", 8'h00, 1'b0);  // R1 state after reset release
    for (int i = 0; i < NVEC; i++) runVec(VECS[i], REQS[i]);

    // R1: reset in the middle of a pending, masked, level-mode state
    runVec('{1'b1, 1'b1, 8'h03, 1'b0, 1'b0, 1'b0, 4'd1, 8'h03, 1'b0}, "R2");
    runVec('{1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd3, 8'h0B, 1'b0}, "R8");
    rstN = 1'b0;
    pinN = 1'b1;
    @(negedge clk);
    check("R1", 8'h00, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    // R10: clear during break in level mode with the pin high, then leave break
    runVec('{1'b0, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 4'd4, 8'h09, 1'b1}, "R5");
    runVec('{1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd3, 8'h09, 1'b1}, "R5");
    runVec('{1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 4'd1, 8'h01, 1'b0}, "R10");
    runVec('{1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd3, 8'h01, 1'b0}, "R10");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    nFails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule